// File: doc/BRIEF.md
# NAND In-Die Page Copyback Sequencer

This block moves one page from a source row to a destination row inside the same NAND die, and the data never crosses the pins. It works in two phases. First it loads the source page into the device's cache register. Once the device reports ready, it programs the cache contents to the destination row. On the way it can overwrite selected bytes of the cached page with new values. These patches are supplied as a stream of column/byte pairs. When the program phase ends, the block polls the device status and reports pass or fail.

A host presents a move request on a valid/ready handshake. The request carries the source row, the destination row, the number of patches and a copy-generation count. The patches arrive on a second valid/ready stream, and the block consumes them in order during phase two. It accepts a patch only when it is about to put that patch on the bus. The host must hold `patch_valid` and its payload stable until the accepting edge, so holding `patch_ready` low is the only back-pressure the block applies. A request whose rows lie on different dies is refused without any bus activity. On completion the block returns the generation count plus one, saturating at the count's all-ones value. It also raises a flag once that count reaches a configured limit, so that higher layers can schedule a rewrite through an error-corrected path.

The NAND side is a one-byte-per-clock model. A cycle with `nand_we` high writes one byte: with `nand_cle` high the byte is a command, with `nand_ale` high it is an address, and with neither high it is data. A cycle with `nand_re` high samples status from `nand_dq_i` in that same cycle.

Top module: `nand_copyback`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R2: The die index is bits [ROW_W-1:ROW_W-DIE_W] of a row. If the source and destination die indices differ, the block produces no `nand_we` strobe and reports `result`=2 on its `done` pulse.
- R3: Phase one writes command 0x00, then five address bytes, then command 0x35. The address bytes in order are column low, column high, row[7:0], row[15:8] and row[23:16]. In phase one both column bytes are 0x00.
- R4: After 0x35, the block waits GUARD cycles and then until `nand_rb` is high. Only then does it write the phase-two command 0x85.
- R5: Phase two writes 0x85 and then five address bytes of the destination row. The column in these bytes is the first patch's column, or 0 when there are no patches. When at least one patch exists, the first patch's data byte follows.
- R6: Each later patch is written, in supply order, as command 0x85, column low, column high and then its data byte.
- R7: `patch_ready` is never high together with `req_ready`. Exactly `req_npatch` patches are accepted per move.
- R8: After the last patch (or the phase-two address, if there are none), the block writes 0x10 and then 0x70. It then raises `nand_re` each cycle until status bit 6 reads 1. At that point it reports `result`=1 if status bit 0 is 1, and `result`=0 otherwise.
- R9: `res_gen` equals `req_gen`+1, saturating at all ones. `res_rewrite` is 1 exactly when `res_gen` >= GEN_LIMIT.
- R10: `done` is a one-cycle pulse, and in the following cycle the block is idle again.
- R11: A `nand_we` strobe never has `nand_cle` and `nand_ale` high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Move request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_src_row | input | ROW_W | Source row address |
| req_dst_row | input | ROW_W | Destination row address |
| req_npatch | input | NP_W | Number of patches to apply |
| req_gen | input | GEN_W | Copy generation of the source data |
| patch_valid | input | 1 | Patch entry valid |
| patch_ready | output | 1 | Patch entry taken this edge if valid |
| patch_col | input | COL_W | Column of the patched byte |
| patch_data | input | 8 | New byte value |
| done | output | 1 | Move finished (one cycle) |
| result | output | 2 | 0 pass, 1 program fail, 2 die mismatch |
| res_gen | output | GEN_W | Generation of the destination page |
| res_rewrite | output | 1 | Generation limit reached |
| nand_ce | output | 1 | Chip enable, high while a move runs |
| nand_cle | output | 1 | Command byte marker |
| nand_ale | output | 1 | Address byte marker |
| nand_we | output | 1 | Byte write strobe |
| nand_re | output | 1 | Status read strobe |
| nand_dq_o | output | 8 | Byte written to the device |
| nand_dq_i | input | 8 | Status byte from the device |
| nand_rb | input | 1 | Device ready (high) / busy (low) |

## Verification
Two events can coincide: the patch stream's handshake and the phase-two resume after ready/busy returns high. The bench provokes this by offering the first patch at a random moment, sometimes well before ready returns and sometimes after, with random busy lengths. It judges the outcome from the logged bus bytes. The first 0x85 must carry `nand_rb` high, and the column must come from the first patch no matter which event came first. The byte order must also match the expected list built from the request.

// File: rtl/nand_cb_pkg.sv
package nand_cb_pkg;
  typedef enum logic [4:0] {
    S_IDLE, S_P1_CMD, S_P1_ADDR, S_P1_CONF, S_GUARD, S_WAIT_RB,
    S_P2_FETCH, S_P2_CMD, S_P2_ADDR, S_PDATA, S_PFETCH, S_PCMD, S_PCOL,
    S_CONF, S_ST_CMD, S_ST_READ, S_DONE
  } cb_state_t;

  localparam logic [7:0] CMD_LOAD      = 8'h00;
  localparam logic [7:0] CMD_LOAD_GO   = 8'h35;
  localparam logic [7:0] CMD_MOVE      = 8'h85;
  localparam logic [7:0] CMD_MOVE_GO   = 8'h10;
  localparam logic [7:0] CMD_STATUS    = 8'h70;

  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_FAIL = 2'd1;
  localparam logic [1:0] RES_DIE  = 2'd2;
endpackage

// File: rtl/nand_cb_die_chk.sv
module nand_cb_die_chk #(
  parameter int ROW_W = 24,
  parameter int DIE_W = 2
) (
  input  logic [ROW_W-1:0] row_a,
  input  logic [ROW_W-1:0] row_b,
  output logic             same_die
);
  localparam int LO = ROW_W - DIE_W;
  always_comb same_die = (row_a[ROW_W-1:LO] == row_b[ROW_W-1:LO]);
endmodule

// File: rtl/nand_cb_addr.sv
module nand_cb_addr #(
  parameter int ROW_W = 24,
  parameter int COL_W = 16
) (
  input  logic [2:0]       idx,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  output logic [7:0]       byte_o
);
  logic [15:0] col_w;
  logic [23:0] row_w;
  always_comb begin
    col_w = 16'(col);
    row_w = 24'(row);
    case (idx)
      3'd0:    byte_o = col_w[7:0];
      3'd1:    byte_o = col_w[15:8];
      3'd2:    byte_o = row_w[7:0];
      3'd3:    byte_o = row_w[15:8];
      default: byte_o = row_w[23:16];
    endcase
  end
endmodule

// File: rtl/nand_cb_gen.sv
module nand_cb_gen #(
  parameter int GEN_W     = 4,
  parameter int GEN_LIMIT = 3
) (
  input  logic [GEN_W-1:0] gen_in,
  output logic [GEN_W-1:0] gen_out,
  output logic             rewrite
);
  always_comb begin
    gen_out = (&gen_in) ? gen_in : gen_in + 1'b1;
    rewrite = (32'(gen_out) >= GEN_LIMIT);
  end
endmodule

// File: rtl/nand_copyback.sv
module nand_copyback
  import nand_cb_pkg::*;
#(
  parameter int ROW_W     = 24,
  parameter int COL_W     = 16,
  parameter int DIE_W     = 2,
  parameter int NP_W      = 3,
  parameter int GEN_W     = 4,
  parameter int GEN_LIMIT = 3,
  parameter int GUARD     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_src_row,
  input  logic [ROW_W-1:0] req_dst_row,
  input  logic [NP_W-1:0]  req_npatch,
  input  logic [GEN_W-1:0] req_gen,
  input  logic             patch_valid,
  output logic             patch_ready,
  input  logic [COL_W-1:0] patch_col,
  input  logic [7:0]       patch_data,
  output logic             done,
  output logic [1:0]       result,
  output logic [GEN_W-1:0] res_gen,
  output logic             res_rewrite,
  output logic             nand_ce,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we,
  output logic             nand_re,
  output logic [7:0]       nand_dq_o,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb
);
  localparam int CNT_W = ($clog2(GUARD + 1) > 3) ? $clog2(GUARD + 1) : 3;

  cb_state_t        state, state_n;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] src_q, dst_q;
  logic [NP_W-1:0]  left_q;
  logic [COL_W-1:0] col_q;
  logic [7:0]       dat_q;
  logic             pend_q, touched_q;
  logic             same_die, gen_rw;
  logic [GEN_W-1:0] gen_nx;
  logic [7:0]       addr_byte;
  logic [COL_W-1:0] addr_col;
  logic [ROW_W-1:0] addr_row;
  logic             take_patch;

  nand_cb_die_chk #(.ROW_W(ROW_W), .DIE_W(DIE_W)) u_die (
    .row_a(req_src_row), .row_b(req_dst_row), .same_die(same_die));

  nand_cb_gen #(.GEN_W(GEN_W), .GEN_LIMIT(GEN_LIMIT)) u_gen (
    .gen_in(req_gen), .gen_out(gen_nx), .rewrite(gen_rw));

  always_comb begin
    addr_col = (state == S_P1_ADDR) ? '0 : col_q;
    addr_row = (state == S_P1_ADDR) ? src_q : dst_q;
  end

  nand_cb_addr #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .idx(cnt[2:0]), .col(addr_col), .row(addr_row), .byte_o(addr_byte));

  assign take_patch = patch_valid && patch_ready;

  // Bus outputs are a pure function of the state
  always_comb begin
    req_ready   = (state == S_IDLE);
    patch_ready = (state == S_P2_FETCH) || (state == S_PFETCH);
    done        = (state == S_DONE);
    nand_ce     = (state != S_IDLE) && (state != S_DONE);
    nand_we     = 1'b0;
    nand_cle    = 1'b0;
    nand_ale    = 1'b0;
    nand_re     = 1'b0;
    nand_dq_o   = 8'h00;
    case (state)
      S_P1_CMD:  begin nand_we = 1'b1; nand_cle = 1'b1; nand_dq_o = CMD_LOAD;    end
      S_P1_CONF: begin nand_we = 1'b1; nand_cle = 1'b1; nand_dq_o = CMD_LOAD_GO; end
      S_P2_CMD, S_PCMD:
                 begin nand_we = 1'b1; nand_cle = 1'b1; nand_dq_o = CMD_MOVE;    end
      S_CONF:    begin nand_we = 1'b1; nand_cle = 1'b1; nand_dq_o = CMD_MOVE_GO; end
      S_ST_CMD:  begin nand_we = 1'b1; nand_cle = 1'b1; nand_dq_o = CMD_STATUS;  end
      S_P1_ADDR, S_P2_ADDR, S_PCOL:
                 begin nand_we = 1'b1; nand_ale = 1'b1; nand_dq_o = addr_byte;   end
      S_PDATA:   begin nand_we = 1'b1; nand_dq_o = dat_q;                        end
      S_ST_READ: nand_re = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    state_n = state;
    case (state)
      S_IDLE:     if (req_valid) state_n = same_die ? S_P1_CMD : S_DONE;
      S_P1_CMD:   state_n = S_P1_ADDR;
      S_P1_ADDR:  if (cnt == CNT_W'(4)) state_n = S_P1_CONF;
      S_P1_CONF:  state_n = S_GUARD;
      S_GUARD:    if (cnt == CNT_W'(GUARD - 1)) state_n = S_WAIT_RB;
      S_WAIT_RB:  if (nand_rb) state_n = (left_q != '0) ? S_P2_FETCH : S_P2_CMD;
      S_P2_FETCH: if (patch_valid) state_n = S_P2_CMD;
      S_P2_CMD:   state_n = S_P2_ADDR;
      S_P2_ADDR:  if (cnt == CNT_W'(4)) state_n = pend_q ? S_PDATA : S_CONF;
      S_PDATA:    state_n = (left_q != '0) ? S_PFETCH : S_CONF;
      S_PFETCH:   if (patch_valid) state_n = S_PCMD;
      S_PCMD:     state_n = S_PCOL;
      S_PCOL:     if (cnt == CNT_W'(1)) state_n = S_PDATA;
      S_CONF:     state_n = S_ST_CMD;
      S_ST_CMD:   state_n = S_ST_READ;
      S_ST_READ:  if (nand_dq_i[6]) state_n = S_DONE;
      S_DONE:     state_n = S_IDLE;
      default:    state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      left_q      <= '0;
      col_q       <= '0;
      dat_q       <= '0;
      pend_q      <= 1'b0;
      touched_q   <= 1'b0;
      result      <= RES_OK;
      res_gen     <= '0;
      res_rewrite <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= (state_n != state) ? '0 : cnt + 1'b1;
      if (nand_we) touched_q <= 1'b1;
      if (state == S_IDLE && req_valid) begin
        src_q       <= req_src_row;
        dst_q       <= req_dst_row;
        left_q      <= req_npatch;
        col_q       <= '0;
        pend_q      <= 1'b0;
        touched_q   <= 1'b0;
        res_gen     <= gen_nx;
        res_rewrite <= gen_rw;
        result      <= same_die ? RES_OK : RES_DIE;
      end
      if (take_patch) begin
        col_q  <= patch_col;
        dat_q  <= patch_data;
        pend_q <= 1'b1;
        left_q <= left_q - 1'b1;
      end
      if (state == S_PDATA) pend_q <= 1'b0;
      if (state == S_ST_READ && nand_dq_i[6])
        result <= nand_dq_i[0] ? RES_FAIL : RES_OK;
    end
  end

  // R11
  cmd_addr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_we |-> !(nand_cle && nand_ale));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R7
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && patch_ready));

  // R2
  die_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_DIE) |-> !touched_q);

  // R4
  resume_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_WAIT_RB && $past(state) == S_WAIT_RB) |-> $past(nand_rb));

  // R8
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_re |-> !nand_we);
endmodule

// File: tb/tb_nand_copyback.sv
module tb_nand_copyback;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 24, COL_W = 16, DIE_W = 2, NP_W = 3, GEN_W = 4;
  localparam int GEN_LIMIT = 3, GUARD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ROW_W-1:0] req_src_row = '0, req_dst_row = '0;
  logic [NP_W-1:0] req_npatch = '0;
  logic [GEN_W-1:0] req_gen = '0;
  logic patch_valid = 1'b0, patch_ready;
  logic [COL_W-1:0] patch_col = '0;
  logic [7:0] patch_data = '0;
  logic done, res_rewrite;
  logic [1:0] result;
  logic [GEN_W-1:0] res_gen;
  logic nand_ce, nand_cle, nand_ale, nand_we, nand_re, nand_rb;
  logic [7:0] nand_dq_o, nand_dq_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_copyback #(.ROW_W(ROW_W), .COL_W(COL_W), .DIE_W(DIE_W), .NP_W(NP_W),
    .GEN_W(GEN_W), .GEN_LIMIT(GEN_LIMIT), .GUARD(GUARD)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src_row(req_src_row), .req_dst_row(req_dst_row),
    .req_npatch(req_npatch), .req_gen(req_gen),
    .patch_valid(patch_valid), .patch_ready(patch_ready),
    .patch_col(patch_col), .patch_data(patch_data),
    .done(done), .result(result), .res_gen(res_gen), .res_rewrite(res_rewrite),
    .nand_ce(nand_ce), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we(nand_we), .nand_re(nand_re), .nand_dq_o(nand_dq_o),
    .nand_dq_i(nand_dq_i), .nand_rb(nand_rb));

  // NAND device model and bus logger: entry = {rb, cle, ale, byte}
  logic [10:0] log_q [64];
  int log_n, re_n, rb_cnt, pg_cnt, busy1, busy2;
  logic fail_bit;
  always @(posedge clk) begin
    if (!rst_n) begin
      log_n <= 0; re_n <= 0; rb_cnt <= 0; pg_cnt <= 0;
    end else begin
      if (nand_we && log_n < 64) begin
        log_q[log_n] <= {nand_rb, nand_cle, nand_ale, nand_dq_o};
        log_n <= log_n + 1;
      end
      if (nand_re) re_n <= re_n + 1;
      if (nand_we && nand_cle && nand_dq_o == 8'h35) rb_cnt <= busy1;
      else if (rb_cnt != 0) rb_cnt <= rb_cnt - 1;
      if (nand_we && nand_cle && nand_dq_o == 8'h10) pg_cnt <= busy2;
      else if (pg_cnt != 0) pg_cnt <= pg_cnt - 1;
    end
  end
  assign nand_rb   = (rb_cnt == 0);
  assign nand_dq_i = {1'b0, (pg_cnt == 0), 5'b0, fail_bit};

  int checks = 0, errors = 0;
  logic [9:0] exp_q [64];
  int exp_n;
  logic [COL_W-1:0] pcol [8];
  logic [7:0] pdat [8];

  task automatic chk(input bit ok, input string req, input string msg,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, msg, act, exp);
    end
  endtask

  function automatic logic [7:0] abyte(input int i, input logic [15:0] c,
                                       input logic [23:0] r);
    case (i)
      0: return c[7:0];
      1: return c[15:8];
      2: return r[7:0];
      3: return r[15:8];
      default: return r[23:16];
    endcase
  endfunction

  task automatic push(input logic cle, input logic ale, input logic [7:0] b);
    exp_q[exp_n] = {cle, ale, b};
    exp_n++;
  endtask

  task automatic build_exp(input logic [23:0] src, input logic [23:0] dst,
                           input int np);
    exp_n = 0;
    push(1, 0, 8'h00);                                // R3
    for (int i = 0; i < 5; i++) push(0, 1, abyte(i, 16'h0, src));
    push(1, 0, 8'h35);
    push(1, 0, 8'h85);                                // R5
    for (int i = 0; i < 5; i++) push(0, 1, abyte(i, (np > 0) ? pcol[0] : 16'h0, dst));
    if (np > 0) push(0, 0, pdat[0]);
    for (int k = 1; k < np; k++) begin                // R6
      push(1, 0, 8'h85);
      push(0, 1, pcol[k][7:0]);
      push(0, 1, pcol[k][15:8]);
      push(0, 0, pdat[k]);
    end
    push(1, 0, 8'h10);                                // R8
    push(1, 0, 8'h70);
  endtask

  task automatic feed(input int np, input int lead);
    for (int k = 0; k < np; k++) begin
      repeat (lead + ($urandom % 3)) @(negedge clk);
      patch_valid = 1'b1; patch_col = pcol[k]; patch_data = pdat[k];
      while (!patch_ready) @(negedge clk);
      @(negedge clk);
      patch_valid = 1'b0;
    end
  endtask

  task automatic run_op(input logic [23:0] src, input logic [23:0] dst,
                        input int np, input logic [3:0] gen, input bit fl,
                        input int lead);
    int wait_n;
    bit die_bad;
    logic [3:0] eg;
    die_bad = (src[23:22] != dst[23:22]);
    fail_bit = fl;
    @(negedge clk);
    chk(req_ready, "R1", "idle ready", req_ready, 1);
    req_src_row = src; req_dst_row = dst; req_npatch = NP_W'(np);
    req_gen = gen; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1", "busy after accept", req_ready, 0);
    wait_n = 0;
    fork
      if (!die_bad) feed(np, lead);
      begin
        while (!done && wait_n < 2000) begin @(negedge clk); wait_n++; end
      end
    join
    chk(done, "R10", "done seen", done, 1);
    eg = (gen == 4'hF) ? 4'hF : gen + 4'd1;
    chk(res_gen == eg, "R9", "gen", res_gen, eg);
    chk(res_rewrite == (eg >= GEN_LIMIT), "R9", "rewrite", res_rewrite, eg >= GEN_LIMIT);
    if (die_bad) begin
      chk(result == 2'd2, "R2", "die result", result, 2);
      chk(log_n == 0, "R2", "no bus writes", log_n, 0);
    end else begin
      chk(result == (fl ? 2'd1 : 2'd0), "R8", "status result", result, fl);
      chk(re_n > 0, "R8", "status read strobes", re_n, 1);
      build_exp(src, dst, np);
      chk(log_n == exp_n, "R6", "byte count", log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++)
        if (log_q[i][9:0] != exp_q[i]) begin
          chk(0, "R5", $sformatf("byte %0d", i), log_q[i][9:0], exp_q[i]);
          break;
        end
      for (int i = 0; i < log_n; i++)
        if (log_q[i][11-2:8] == 2'b10 && log_q[i][7:0] == 8'h85) begin
          chk(log_q[i][10], "R4", "rb high at first 0x85", log_q[i][10], 1);
          break;
        end
      for (int i = 0; i < log_n; i++)
        if (log_q[i][9] && log_q[i][8])
          chk(0, "R11", "cle and ale together", i, 0);
    end
    @(negedge clk);
    chk(!done && req_ready, "R10", "one-cycle done, idle", done, 0);
    rst_n = 1'b1;
    // clear the log through a short reset of the model only
    force log_n = 0; force re_n = 0;
    @(negedge clk);
    release log_n; release re_n;
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    fail_bit = 1'b0; busy1 = 3; busy2 = 4;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && nand_we == 1'b0 && patch_ready == 1'b0,
        "R1", "reset state", {req_ready, done, nand_we, patch_ready}, 4'b1000);
    rst_n = 1'b1;
    // directed corners
    run_op(24'h41_2345, 24'h7F_0011, 0, 4'd0, 0, 0);      // no patch
    run_op(24'h41_2345, 24'h81_0011, 2, 4'd1, 0, 0);      // die mismatch R2
    for (int k = 0; k < 8; k++) begin pcol[k] = 16'(k * 37 + 5); pdat[k] = 8'(k * 29 + 1); end
    busy1 = 12;
    run_op(24'hC0_0100, 24'hC3_FF00, 7, 4'd2, 1, 0);      // max patches, fail, patch early
    busy1 = 0;
    run_op(24'h00_0001, 24'h3F_FFFF, 3, 4'hF, 0, 20);     // patch late, gen saturate
    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [23:0] s, d;
      int np;
      s = 24'($urandom); d = 24'($urandom);
      if (($urandom % 6) != 0) d[23:22] = s[23:22];
      np = $urandom % 8;
      for (int k = 0; k < 8; k++) begin pcol[k] = 16'($urandom); pdat[k] = 8'($urandom); end
      busy1 = $urandom % 20; busy2 = $urandom % 20;
      run_op(s, d, np, 4'($urandom), $urandom % 2, $urandom % 15);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule